// File: doc/BRIEF.md
# Dual-Mode Machine-Cycle Timer

This block is a small timer/counter of the kind found beside an 8-bit processor core. A free-running divider turns the system clock into machine cycles, one per twelve clock periods. While its run bit is set, the counter advances once per machine cycle. Software drives the timer through a byte-wide register port. The port holds a mode byte, a control byte, the low and high count bytes and a reload byte. The mode byte chooses one of two counting styles.

The first style chains the two count bytes into one 16-bit up-counter. When it passes all-ones it restarts from zero, and software must rewrite both bytes if it wants a different start value. The second style counts only the low byte. When that byte passes all-ones it reloads itself from the reload byte with no software action, and the high byte is left alone.

Each overflow sets a sticky flag. The flag drives an interrupt request, which is raised only when both a timer enable and a global enable are set. The flag is cleared by a software write or by an acknowledge pulse.

Top module: `tmr_timer`

## Requirements
- R1: The divider runs freely from reset, whatever the run bit holds. A running counter advances exactly once every 12 clock cycles, and consecutive advances are 12 cycles apart.
- R2: When MODE bits [1:0] are not 2 (for example the value 0x01), {HI,LO} is one 16-bit up-counter. An advance from 0xFFFF gives 0x0000, with no reload.
- R3: When MODE bits [1:0] equal 2, only LO counts. An advance from 0xFF loads LO from the RELOAD register, and HI is unchanged.
- R4: While CTRL bit 0 (run) is 0, neither count byte changes except by a software write.
- R5: An overflow (either style) sets CTRL bit 1 (flag) on the same clock edge on which the count wraps or reloads.
- R6: The flag clears on an irq_ack pulse or on a CTRL write with bit 1 equal to 0. If an overflow falls in the same cycle, the overflow wins and the flag ends up set.
- R7: irq is high exactly when flag, CTRL bit 2 (timer enable) and CTRL bit 3 (global enable) are all 1.
- R8: A write to LO or HI takes priority over an advance in the same cycle. The written byte takes the data, and no byte advances in that cycle.
- R9: The register addresses are 0 MODE, 1 CTRL, 2 LO, 3 HI and 4 RELOAD. Every register resets to 0. CTRL bits [7:4] and unmapped addresses read as 0. rd_data reflects addr combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at addr |
| addr | input | 3 | Register address for both read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the register at addr |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| irq | output | 1 | Gated interrupt request |

## Verification
The bench builds the timer with its default divider of 12 and byte width of 8. With these values, a 16-bit wrap from zero would take about 786,000 clocks. The bench therefore preloads the count bytes near all-ones, so that wraps, reloads and same-cycle conflicts between writes, acknowledges and overflows occur within a few hundred cycles. A behavioural model tracks every register and the request on each clock. Directed phases check the advance spacing and both wrap styles, and a soak phase mixes writes and acknowledges at random.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
    localparam logic [ADDR_W-1:0] A_LO   = 3'd2;
    localparam logic [ADDR_W-1:0] A_HI   = 3'd3;
    localparam logic [ADDR_W-1:0] A_RLD  = 3'd4;

    // control byte bit positions
    localparam int CB_RUN  = 0;
    localparam int CB_FLAG = 1;
    localparam int CB_TIE  = 2;
    localparam int CB_GIE  = 3;

    localparam logic [1:0] MODE_AUTO8 = 2'd2;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] ps_d, ps_q;

    always_comb begin
        tick = (ps_q == LAST);
        ps_d = tick ? '0 : ps_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run,
    input  logic          auto8,
    input  logic [BW-1:0] rld,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [BW-1:0] wdata,
    output logic [BW-1:0] cnt_lo,
    output logic [BW-1:0] cnt_hi,
    output logic          ovf
);
    typedef struct packed {
        logic [BW-1:0] hi;
        logic [BW-1:0] lo;
    } cnt_t;

    cnt_t c_d, c_q;
    logic adv;

    always_comb begin
        c_d = c_q;
        ovf = 1'b0;
        adv = tick & run & ~(wr_lo | wr_hi);
        if (wr_lo) c_d.lo = wdata;
        if (wr_hi) c_d.hi = wdata;
        if (adv) begin
            if (auto8) begin
                if (&c_q.lo) begin
                    c_d.lo = rld;
                    ovf    = 1'b1;
                end else begin
                    c_d.lo = c_q.lo + 1'b1;
                end
            end else begin
                {c_d.hi, c_d.lo} = {c_q.hi, c_q.lo} + 1'b1;
                ovf              = &{c_q.hi, c_q.lo};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt_lo = c_q.lo;
    assign cnt_hi = c_q.hi;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BW-1:0]     wdata,
    input  logic              irq_ack,
    input  logic              ovf,
    output logic [BW-1:0]     mode,
    output logic [BW-1:0]     rld,
    output logic              run,
    output logic              flag,
    output logic              tie,
    output logic              gie,
    output logic              auto8,
    output logic              irq
);
    typedef struct packed {
        logic [BW-1:0] mode;
        logic [BW-1:0] rld;
        logic          run;
        logic          flag;
        logic          tie;
        logic          gie;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (addr)
                A_MODE: r_d.mode = wdata;
                A_RLD:  r_d.rld  = wdata;
                A_CTRL: begin
                    r_d.run  = wdata[CB_RUN];
                    r_d.flag = wdata[CB_FLAG];
                    r_d.tie  = wdata[CB_TIE];
                    r_d.gie  = wdata[CB_GIE];
                end
                default: ;
            endcase
        end
        if (irq_ack) r_d.flag = 1'b0;
        if (ovf)     r_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mode  = r_q.mode;
    assign rld   = r_q.rld;
    assign run   = r_q.run;
    assign flag  = r_q.flag;
    assign tie   = r_q.tie;
    assign gie   = r_q.gie;
    assign auto8 = (r_q.mode[1:0] == MODE_AUTO8);
    assign irq   = r_q.flag & r_q.tie & r_q.gie;
endmodule

// File: rtl/tmr_timer.sv
module tmr_timer
    import tmr_pkg::*;
#(
    parameter int DIV = 12,
    parameter int BW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BW-1:0]     wr_data,
    output logic [BW-1:0]     rd_data,
    input  logic              irq_ack,
    output logic              irq
);
    logic          tick, ovf, run, flag, tie, gie, auto8;
    logic          wr_lo, wr_hi;
    logic [BW-1:0] mode, rld, cnt_lo, cnt_hi;

    assign wr_lo = wr_en && (addr == A_LO);
    assign wr_hi = wr_en && (addr == A_HI);

    tmr_prescale #(.DIV(DIV)) u_ps (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    tmr_count #(.BW(BW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .run    (run),
        .auto8  (auto8),
        .rld    (rld),
        .wr_lo  (wr_lo),
        .wr_hi  (wr_hi),
        .wdata  (wr_data),
        .cnt_lo (cnt_lo),
        .cnt_hi (cnt_hi),
        .ovf    (ovf)
    );

    tmr_regs #(.BW(BW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wr_data),
        .irq_ack (irq_ack),
        .ovf     (ovf),
        .mode    (mode),
        .rld     (rld),
        .run     (run),
        .flag    (flag),
        .tie     (tie),
        .gie     (gie),
        .auto8   (auto8),
        .irq     (irq)
    );

    always_comb begin
        rd_data = '0;
        case (addr)
            A_MODE: rd_data = mode;
            A_LO:   rd_data = cnt_lo;
            A_HI:   rd_data = cnt_hi;
            A_RLD:  rd_data = rld;
            A_CTRL: begin
                rd_data[CB_RUN]  = run;
                rd_data[CB_FLAG] = flag;
                rd_data[CB_TIE]  = tie;
                rd_data[CB_GIE]  = gie;
            end
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
    parameter int DIV = 12,
    parameter int BW  = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          run,
    input logic          auto8,
    input logic          wr_lo,
    input logic          wr_hi,
    input logic [BW-1:0] wdata,
    input logic [BW-1:0] cnt_lo,
    input logic [BW-1:0] cnt_hi,
    input logic [BW-1:0] rld,
    input logic          flag,
    input logic          tie,
    input logic          gie,
    input logic          irq,
    input logic          irq_ack,
    input logic          ovf
);
    localparam int GW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [GW-1:0] GAP = GW'(DIV - 1);

    // cycles since the previous machine-cycle tick
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    gap_q <= '0;
        else if (tick) gap_q <= '0;
        else           gap_q <= gap_q + 1'b1;
    end

    assert_tick_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> gap_q == GAP);

    assert_wrap16_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && !auto8 && !wr_lo && !wr_hi && (&{cnt_hi, cnt_lo}))
        |=> ({cnt_hi, cnt_lo} == '0));

    assert_reload8_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && auto8 && !wr_lo && !wr_hi && (&cnt_lo))
        |=> (cnt_lo == $past(rld)) && $stable(cnt_hi));

    assert_hold_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_lo && !wr_hi) |=> $stable(cnt_lo) && $stable(cnt_hi));

    assert_flag_on_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> flag);

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !ovf) |=> !flag);

    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tie || !gie || !flag) |-> !irq);

    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> cnt_lo == $past(wdata));
endmodule

bind tmr_timer tmr_chk #(.DIV(DIV), .BW(BW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .run     (run),
    .auto8   (auto8),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .wdata   (wr_data),
    .cnt_lo  (cnt_lo),
    .cnt_hi  (cnt_hi),
    .rld     (rld),
    .flag    (flag),
    .tie     (tie),
    .gie     (gie),
    .irq     (irq),
    .irq_ack (irq_ack),
    .ovf     (ovf)
);

// File: tb/tmr_timer_test.sv
module tmr_timer_test;
    localparam int DIV = 12;
    localparam int BW  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       irq_ack = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       irq;

    always #10 clk = ~clk;

    tmr_timer #(.DIV(DIV), .BW(BW)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq_ack (irq_ack),
        .irq     (irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // behavioural reference state
    int m_ps, m_lo, m_hi, m_rld, m_mode, m_run, m_flag, m_tie, m_gie;

    always @(posedge clk) begin : ref_model
        int tk, ov, c16;
        if (!rst_n) begin
            m_ps = 0; m_lo = 0; m_hi = 0; m_rld = 0; m_mode = 0;
            m_run = 0; m_flag = 0; m_tie = 0; m_gie = 0;
        end else begin
            tk = (m_ps == DIV - 1);
            m_ps = tk ? 0 : m_ps + 1;
            ov = 0;
            if (wr_en && (addr == 3'd2 || addr == 3'd3)) begin
                if (addr == 3'd2) m_lo = wr_data;
                else              m_hi = wr_data;
            end else if (tk && m_run != 0) begin
                if ((m_mode % 4) == 2) begin
                    if (m_lo == 255) begin m_lo = m_rld; ov = 1; end
                    else m_lo = m_lo + 1;
                end else begin
                    c16 = m_hi * 256 + m_lo + 1;
                    if (c16 == 65536) begin c16 = 0; ov = 1; end
                    m_hi = c16 / 256;
                    m_lo = c16 % 256;
                end
            end
            if (wr_en) begin
                case (addr)
                    3'd0: m_mode = wr_data;
                    3'd1: begin
                        m_run  = wr_data[0];
                        m_flag = wr_data[1];
                        m_tie  = wr_data[2];
                        m_gie  = wr_data[3];
                    end
                    3'd4: m_rld = wr_data;
                    default: ;
                endcase
            end
            if (irq_ack) m_flag = 0;
            if (ov != 0) m_flag = 1;
        end
    end

    function automatic int exp_rd(input int a);
        case (a)
            0: return m_mode;
            1: return m_run + 2 * m_flag + 4 * m_tie + 8 * m_gie;
            2: return m_lo;
            3: return m_hi;
            4: return m_rld;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic cmp_now();
        string t;
        case (addr)
            3'd1:       t = "R5 control readback vs model";
            3'd2, 3'd3: t = "R2 count readback vs model";
            default:    t = "R9 register readback vs model";
        endcase
        check(t, rd_data, exp_rd(addr));
        check("R7 irq vs model", irq, (m_flag & m_tie & m_gie));
    endtask

    task automatic step(input logic we, input logic [2:0] a, input logic [7:0] d, input logic ak);
        @(negedge clk);
        cmp_now();
        wr_en = we; addr = a; wr_data = d; irq_ack = ak;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        step(1'b1, a, d, 1'b0);
    endtask

    task automatic peek(input logic [2:0] a, output int v);
        step(1'b0, a, 8'd0, 1'b0);
        #1 v = rd_data;
    endtask

    task automatic wait_flag(output int v);
        for (int i = 0; i < 600; i++) begin
            peek(3'd1, v);
            if ((v & 2) != 0) break;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int v, v2, last, pv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset values
        for (int a = 0; a < 6; a++) begin
            peek(3'(a), v);
            check("R9 reset value", v, 0);
        end
        check("R7 irq low after reset", irq, 0);

        // R1: advance spacing in 16-bit mode
        wr(3'd0, 8'h01); wr(3'd3, 8'h00); wr(3'd2, 8'h00); wr(3'd1, 8'h01);
        last = -1; pv = 0;
        for (int i = 0; i < 80; i++) begin
            peek(3'd2, v);
            if (v != pv) begin
                if (last >= 0) check("R1 machine-cycle spacing", i - last, 12);
                last = i; pv = v;
            end
        end

        // R2 / R5: 16-bit wrap without reload
        wr(3'd1, 8'h00); wr(3'd3, 8'hFF); wr(3'd2, 8'hF0); wr(3'd1, 8'h01);
        wait_flag(v);
        check("R5 flag after 16-bit wrap", v & 2, 2);
        peek(3'd3, v); check("R2 high byte after wrap", v, 8'h00);
        peek(3'd2, v); check("R2 low byte after wrap", v, 8'h00);

        // R6: acknowledge clears the flag
        step(1'b0, 3'd1, 8'd0, 1'b1);
        peek(3'd1, v); check("R6 ack clears flag", v & 2, 0);

        // R7: request gating
        wr(3'd1, 8'h03); peek(3'd1, v); check("R7 irq with enables off", irq, 0);
        wr(3'd1, 8'h07); peek(3'd1, v); check("R7 irq with global enable off", irq, 0);
        wr(3'd1, 8'h0F); peek(3'd1, v); check("R7 irq with all set", irq, 1);
        wr(3'd1, 8'h0D); peek(3'd1, v);
        check("R6 software write clears flag", v & 2, 0);
        check("R7 irq drops with flag", irq, 0);

        // R3: 8-bit auto-reload
        wr(3'd1, 8'h00); wr(3'd0, 8'h02); wr(3'd4, 8'hF8);
        wr(3'd3, 8'h55); wr(3'd2, 8'hFC); wr(3'd1, 8'h01);
        wait_flag(v);
        check("R5 flag after 8-bit reload", v & 2, 2);
        peek(3'd2, v); check("R3 low byte reloaded", v, 8'hF8);
        peek(3'd3, v); check("R3 high byte untouched", v, 8'h55);
        step(1'b0, 3'd1, 8'd0, 1'b1);
        wait_flag(v);
        peek(3'd2, v); check("R3 second reload", v, 8'hF8);

        // R4: stopped counter holds
        wr(3'd1, 8'h00);
        peek(3'd2, v);
        repeat (60) step(1'b0, 3'd2, 8'd0, 1'b0);
        peek(3'd2, v2); check("R4 count holds while stopped", v2, v);

        // R8: writes every cycle keep the low byte fixed while running
        wr(3'd0, 8'h01); wr(3'd1, 8'h01);
        for (int i = 0; i < 40; i++) begin
            step(1'b1, 3'd2, 8'h10, 1'b0);
            #1;
            if (i > 0) check("R8 write beats advance", rd_data, 8'h10);
        end

        // soak: mixed traffic checked against the model every cycle
        for (int i = 0; i < 8000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 4)       wr(3'd2, 8'($urandom_range(240, 255)));
            else if (r < 6)  wr(3'd3, 8'($urandom_range(250, 255)));
            else if (r < 8)  wr(3'd1, 8'($urandom_range(0, 15) | 1));
            else if (r < 9)  wr(3'd0, 8'($urandom_range(1, 2)));
            else if (r < 10) wr(3'd4, 8'($urandom_range(200, 255)));
            else if (r < 14) step(1'b0, 3'($urandom_range(0, 5)), 8'd0, 1'b1);
            else             step(1'b0, 3'($urandom_range(0, 5)), 8'd0, 1'b0);
        end

        step(1'b0, 3'd0, 8'd0, 1'b0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule